// File: doc/BRIEF.md
# SATA Port Command and Status Register

This block is the 32-bit command and status register of one SATA host controller port. Software reaches it through a plain register write strobe with a data word, and reads its current contents back combinationally. The block keeps the bits that software controls, shows the bits that the port hardware owns, and turns certain changes of the control bits into single-clock pulses. The rest of the port logic acts on those pulses: it starts or stops the command engine, clears the task-file busy flags, starts a link reset or enters listen mode.

A write is a full-word write. In the cycle of the strobe, each control bit's new value is compared with its stored value, and that comparison decides which side effects fire. Some effects need a reply from hardware before they finish. A stop clears the command-issue register only after the command engine reports that it is idle. The override bit stays set until the task-file busy and data-request flags have both dropped.

Top module: `port_cmd_reg`

## Requirements
- R1: After reset the register reads 0x00400000. Bit 22, the switching-capable flag, is the only bit that reads 1. All pulse outputs are 0 and fisRxEn is 0.
- R2: Software writes do not change bits 22:18, bit 2 or bits 7:5. Bit 22 always reads 1, and bits 21:18, bit 2 and bits 7:5 always read 0.
- R3: Bits 31:23, bit 17, bit 4 (FIS-receive enable), bit 1 (spin-up) and bit 0 (start) hold the value last written to them. Output fisRxEn follows bit 4.
- R4: A write that changes bit 0 from 0 to 1 with bit 4 = 1 in the same word pulses startPulse high for one cycle, in the cycle after the write edge.
- R5: A write that changes bit 0 from 0 to 1 with bit 4 = 0 still stores bit 0 as 1. No startPulse follows, and startErr pulses high for one cycle in the cycle after the write edge.
- R6: A write that changes bit 0 from 1 to 0 leaves a stop pending. ciClearPulse fires for one cycle after the first later clock edge at which engIdle is 1. While engIdle stays 0 it does not fire.
- R7: Writing 1 to bit 3 (override) sets bit 3 and pulses tfClearPulse for one cycle. Bit 3 reads 0 again one cycle after a clock edge at which tfBsy and tfDrq are both sampled 0. Writing 0 to bit 3 leaves it unchanged.
- R8: A 0-to-1 change of bit 1 pulses comresetPulse for one cycle. A write that keeps bit 1 at 1 produces no pulse.
- R9: A 1-to-0 change of bit 1 pulses listenPulse for one cycle when detCtrl is 0. With detCtrl nonzero it produces no pulse, and it never produces comresetPulse.
- R10: Bits 16, 15, 14 and 13 show coldPresHw, cmdRunHw, fisRunHw and mechSwHw as sampled at the previous clock edge. Software writes to these positions have no effect.
- R11: Bits 12:8 show slotHw as sampled at the previous edge while bit 0 is 1, and read 0 while bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Write data word |
| rdData | output | 32 | Current register contents |
| engIdle | input | 1 | Command engine reports idle |
| tfBsy | input | 1 | Task-file busy flag |
| tfDrq | input | 1 | Task-file data-request flag |
| detCtrl | input | 4 | Detection control field of the link control register |
| cmdRunHw | input | 1 | Command DMA engine running |
| fisRunHw | input | 1 | FIS-receive DMA engine running |
| coldPresHw | input | 1 | Cold-presence device detected |
| mechSwHw | input | 1 | Mechanical presence switch state |
| slotHw | input | 5 | Slot currently being issued |
| fisRxEn | output | 1 | FIS-receive enable level |
| startPulse | output | 1 | Begin command processing at slot 0 |
| startErr | output | 1 | Start requested with FIS receive disabled |
| ciClearPulse | output | 1 | Clear the command-issue register |
| tfClearPulse | output | 1 | Clear task-file BSY and DRQ |
| comresetPulse | output | 1 | Start a link reset sequence |
| listenPulse | output | 1 | Enter listen mode |

## Verification
The assertions assume that the task-file flags answer a clear pulse within a few cycles. They also assume that engIdle eventually rises after a stop, and that every input settles before the clock edge that samples it. The bench holds the flags busy only for as long as a check needs, then drops them. It keeps engIdle low while it checks a pending stop, and raises it afterwards. It changes every input half a period away from the sampling edge.

// File: rtl/port_cmd_pkg.sv
package port_cmd_pkg;
  localparam int REG_W  = 32;
  localparam int SLOT_W = 5;
  localparam int DET_W  = 4;

  localparam int BIT_ST   = 0;
  localparam int BIT_SUD  = 1;
  localparam int BIT_CLO  = 3;
  localparam int BIT_FRE  = 4;
  localparam int SLOT_LSB = 8;
  localparam int BIT_MPSS = 13;
  localparam int BIT_FR   = 14;
  localparam int BIT_CR   = 15;
  localparam int BIT_CPS  = 16;

  localparam logic [REG_W-1:0] FIXED_ONES = 32'h0040_0000;
  localparam logic [REG_W-1:0] SW_MASK    = 32'hFF82_0013;

  typedef struct packed {
    logic startRise;
    logic stopFall;
    logic cloSet;
    logic cloDone;
    logic sudRise;
    logic sudFall;
  } strobe_t;
endpackage

// File: rtl/port_cmd_dp.sv
module port_cmd_dp
  import port_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  input  strobe_t           stb,
  input  logic              tfBsy,
  input  logic              tfDrq,
  input  logic              cmdRunHw,
  input  logic              fisRunHw,
  input  logic              coldPresHw,
  input  logic              mechSwHw,
  input  logic [SLOT_W-1:0] slotHw,
  output logic [REG_W-1:0]  rdData,
  output logic              stQ,
  output logic              sudQ,
  output logic              cloQ,
  output logic              freQ
);
  logic [REG_W-1:0]  swBits;
  logic [3:0]        hwStat;
  logic [SLOT_W-1:0] slotQ;
  logic [REG_W-1:0]  statWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swBits <= '0;
    end else if (wrEn) begin
      swBits <= (swBits & ~SW_MASK) | (wrData & SW_MASK);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cloQ <= 1'b0;
    end else if (stb.cloSet) begin
      cloQ <= 1'b1;
    end else if (stb.cloDone) begin
      cloQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hwStat <= '0;
      slotQ  <= '0;
    end else begin
      hwStat <= {coldPresHw, cmdRunHw, fisRunHw, mechSwHw};
      slotQ  <= slotHw;
    end
  end

  always_comb begin
    statWord = '0;
    statWord[BIT_CPS]  = hwStat[3];
    statWord[BIT_CR]   = hwStat[2];
    statWord[BIT_FR]   = hwStat[1];
    statWord[BIT_MPSS] = hwStat[0];
    if (swBits[BIT_ST]) statWord[SLOT_LSB +: SLOT_W] = slotQ;
    statWord[BIT_CLO]  = cloQ;
  end

  assign rdData = swBits | statWord | FIXED_ONES;
  assign stQ    = swBits[BIT_ST];
  assign sudQ   = swBits[BIT_SUD];
  assign freQ   = swBits[BIT_FRE];

  a_r7_clo_release: assert property (@(posedge clk) disable iff (!rstN)
    (cloQ && !tfBsy && !tfDrq && !(wrEn && wrData[BIT_CLO])) |=> !cloQ);
  a_r10_cr_follow: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdData[BIT_CR]) |-> $past(cmdRunHw));
endmodule

// File: rtl/port_cmd_ctrl.sv
module port_cmd_ctrl
  import port_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             stQ,
  input  logic             sudQ,
  input  logic             cloQ,
  input  logic             tfBsy,
  input  logic             tfDrq,
  input  logic             engIdle,
  input  logic [DET_W-1:0] detCtrl,
  output strobe_t          stb,
  output logic             startPulse,
  output logic             startErr,
  output logic             ciClearPulse,
  output logic             tfClearPulse,
  output logic             comresetPulse,
  output logic             listenPulse
);
  logic stopPending;

  always_comb begin
    stb.startRise = wrEn &&  wrData[BIT_ST]  && !stQ;
    stb.stopFall  = wrEn && !wrData[BIT_ST]  &&  stQ;
    stb.cloSet    = wrEn &&  wrData[BIT_CLO];
    stb.cloDone   = cloQ && !tfBsy && !tfDrq;
    stb.sudRise   = wrEn &&  wrData[BIT_SUD] && !sudQ;
    stb.sudFall   = wrEn && !wrData[BIT_SUD] &&  sudQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startPulse    <= 1'b0;
      startErr      <= 1'b0;
      tfClearPulse  <= 1'b0;
      comresetPulse <= 1'b0;
      listenPulse   <= 1'b0;
    end else begin
      startPulse    <= stb.startRise &&  wrData[BIT_FRE];
      startErr      <= stb.startRise && !wrData[BIT_FRE];
      tfClearPulse  <= stb.cloSet;
      comresetPulse <= stb.sudRise;
      listenPulse   <= stb.sudFall && (detCtrl == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopPending  <= 1'b0;
      ciClearPulse <= 1'b0;
    end else begin
      ciClearPulse <= stopPending && engIdle && !stb.startRise;
      if (stb.stopFall)
        stopPending <= 1'b1;
      else if (stb.startRise || engIdle)
        stopPending <= 1'b0;
    end
  end

  a_r4_start_with_run: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> stQ);
  a_r6_clear_after_idle: assert property (@(posedge clk) disable iff (!rstN)
    ciClearPulse |-> $past(engIdle));
  a_r12_start_single: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);
  a_r8_comreset_single: assert property (@(posedge clk) disable iff (!rstN)
    comresetPulse |=> !comresetPulse);
  a_r9_listen_not_reset: assert property (@(posedge clk) disable iff (!rstN)
    listenPulse |-> !sudQ);
endmodule

// File: rtl/port_cmd_reg.sv
module port_cmd_reg
  import port_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic              engIdle,
  input  logic              tfBsy,
  input  logic              tfDrq,
  input  logic [DET_W-1:0]  detCtrl,
  input  logic              cmdRunHw,
  input  logic              fisRunHw,
  input  logic              coldPresHw,
  input  logic              mechSwHw,
  input  logic [SLOT_W-1:0] slotHw,
  output logic              fisRxEn,
  output logic              startPulse,
  output logic              startErr,
  output logic              ciClearPulse,
  output logic              tfClearPulse,
  output logic              comresetPulse,
  output logic              listenPulse
);
  strobe_t stb;
  logic stQ, sudQ, cloQ, freQ;

  port_cmd_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .stQ(stQ), .sudQ(sudQ), .cloQ(cloQ), .tfBsy(tfBsy), .tfDrq(tfDrq),
    .engIdle(engIdle), .detCtrl(detCtrl), .stb(stb),
    .startPulse(startPulse), .startErr(startErr), .ciClearPulse(ciClearPulse),
    .tfClearPulse(tfClearPulse), .comresetPulse(comresetPulse),
    .listenPulse(listenPulse)
  );

  port_cmd_dp i_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .stb(stb),
    .tfBsy(tfBsy), .tfDrq(tfDrq), .cmdRunHw(cmdRunHw), .fisRunHw(fisRunHw),
    .coldPresHw(coldPresHw), .mechSwHw(mechSwHw), .slotHw(slotHw),
    .rdData(rdData), .stQ(stQ), .sudQ(sudQ), .cloQ(cloQ), .freQ(freQ)
  );

  assign fisRxEn = freQ;
endmodule

// File: tb/test_port_cmd_reg.sv
module test_port_cmd_reg;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic engIdle = 1'b1, tfBsy = 1'b0, tfDrq = 1'b0;
  logic [3:0] detCtrl = '0;
  logic cmdRunHw = 1'b0, fisRunHw = 1'b0, coldPresHw = 1'b0, mechSwHw = 1'b0;
  logic [4:0] slotHw = '0;
  logic fisRxEn, startPulse, startErr, ciClearPulse, tfClearPulse, comresetPulse, listenPulse;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  port_cmd_reg i_port_cmd_reg (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 value", rdData, 32'h0040_0000);
    chk("R1 pulses", {28'd0, startPulse, startErr, ciClearPulse, tfClearPulse}, 0);
    chk("R1 fisRxEn", {31'd0, fisRxEn}, 0);
  endtask

  task automatic t_masks();
    wr(32'hFF82_0010);
    chk("R3 writable", rdData, 32'hFFC2_0010);
    chk("R3 fisRxEn", {31'd0, fisRxEn}, 1);
    wr(32'h007D_E0E4);
    chk("R2 read-only", rdData, 32'h0040_0000);
    chk("R10 write ignored", {31'd0, rdData[15]}, 0);
  endtask

  task automatic t_start_ok();
    wr(32'h0000_0010);
    wr(32'h0000_0011);
    chk("R4 startPulse", {31'd0, startPulse}, 1);
    chk("R4 no err", {31'd0, startErr}, 0);
    tick();
    chk("R4 one cycle", {31'd0, startPulse}, 0);
  endtask

  task automatic t_stop();
    engIdle = 1'b0;
    wr(32'h0000_0010);
    chk("R6 not yet", {31'd0, ciClearPulse}, 0);
    tick(); tick();
    chk("R6 wait idle", {31'd0, ciClearPulse}, 0);
    engIdle = 1'b1;
    tick();
    chk("R6 clear", {31'd0, ciClearPulse}, 1);
    tick();
    chk("R6 one cycle", {31'd0, ciClearPulse}, 0);
  endtask

  task automatic t_start_err();
    wr(32'h0000_0000);
    tick();
    wr(32'h0000_0001);
    chk("R5 no start", {31'd0, startPulse}, 0);
    chk("R5 err", {31'd0, startErr}, 1);
    chk("R5 stored", {31'd0, rdData[0]}, 1);
    tick();
    chk("R5 err one cycle", {31'd0, startErr}, 0);
    wr(32'h0000_0000);
    tick();
  endtask

  task automatic t_clo();
    tfBsy = 1'b1; tfDrq = 1'b1;
    wr(32'h0000_0008);
    chk("R7 set", {31'd0, rdData[3]}, 1);
    chk("R7 tfClear", {31'd0, tfClearPulse}, 1);
    tick();
    chk("R7 hold busy", {31'd0, rdData[3]}, 1);
    chk("R7 pulse once", {31'd0, tfClearPulse}, 0);
    wr(32'h0000_0000);
    chk("R7 write zero no effect", {31'd0, rdData[3]}, 1);
    tfBsy = 1'b0;
    tick();
    chk("R7 drq still set", {31'd0, rdData[3]}, 1);
    tfDrq = 1'b0;
    tick();
    chk("R7 released", {31'd0, rdData[3]}, 0);
  endtask

  task automatic t_spinup();
    wr(32'h0000_0002);
    chk("R8 comreset", {31'd0, comresetPulse}, 1);
    tick();
    chk("R8 one cycle", {31'd0, comresetPulse}, 0);
    wr(32'h0000_0002);
    chk("R8 no repeat", {31'd0, comresetPulse}, 0);
    detCtrl = 4'h1;
    wr(32'h0000_0000);
    chk("R9 no listen when det nonzero", {30'd0, listenPulse, comresetPulse}, 0);
    wr(32'h0000_0002);
    detCtrl = 4'h0;
    wr(32'h0000_0000);
    chk("R9 listen", {30'd0, listenPulse, comresetPulse}, 2);
    tick();
    chk("R9 one cycle", {31'd0, listenPulse}, 0);
  endtask

  task automatic t_status();
    cmdRunHw = 1'b1; coldPresHw = 1'b1;
    tick();
    chk("R10 status", {28'd0, rdData[16:13]}, 4'b1100);
    fisRunHw = 1'b1; mechSwHw = 1'b1; cmdRunHw = 1'b0;
    wr(32'h0000_0000);
    chk("R10 status follow", {28'd0, rdData[16:13]}, 4'b1011);
    slotHw = 5'd19;
    tick();
    chk("R11 slot zero when stopped", {27'd0, rdData[12:8]}, 0);
    wr(32'h0000_0011);
    chk("R11 slot shown", {27'd0, rdData[12:8]}, 19);
    slotHw = 5'd7;
    tick();
    chk("R11 slot follow", {27'd0, rdData[12:8]}, 7);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        tick();
        t_reset();
        t_masks();
        t_start_ok();
        t_stop();
        t_start_err();
        t_clo();
        t_spinup();
        t_status();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule